// File: doc/BRIEF.md
# Stereo Attenuator Volume Encoder and Shifter

This block turns an 8-bit linear volume request and a mute flag into the control word of a two-channel electronic attenuator. It then sends that word over a three-wire serial link of data, clock and strobe lines. The volume is mapped to decibels of attenuation along three straight-line segments, with the steepest drop at low volume. The attenuation is split into a tens-of-dB field and a 2-dB-step field, each one-hot encoded. Both channel-select bits are always set, so the left and right outputs always receive the same code.

A transfer starts with a one-cycle `start_i` pulse while the block is idle. The block holds `busy_o` high while it shifts the 18-bit word out, least significant bit first, and then pulses the strobe to latch the word. `done_o` goes high for one cycle at the end. Every line phase lasts `DIV` system clocks. At the start of each transfer the block also latches the quantised volume that the chip will actually apply, and reports it on `level_o`.

Top module: `atten_link_top`

## Requirements
- R1: After reset, `ser_data_o`, `ser_clk_o`, `ser_strobe_o`, `busy_o`, `done_o` and `level_o` are all 0.
- R2: With M = 255 and integer division, attenuation A in dB is: 68 for v = 0; 68 − 144·v/M for 1 ≤ v ≤ 85; 34 − 42·v/M for 86 ≤ v ≤ 170; and 18 − 18·v/M for v ≥ 171.
- R3: Let T = A/10. Word bits 0..6 hold a one-hot code with only bit T set.
- R4: Let U = A − 10·T. Word bits 7..11 hold a one-hot code with only bit 7 + U/2 set. An odd U rounds down to the lower 2 dB step.
- R5: Word bit 13 (left) and bit 14 (right) are 1. Bit 12 and bits 15..17 are 0.
- R6: The 18 word bits are sent LSB first. For each bit, `ser_data_o` is driven while `ser_clk_o` is low for DIV cycles, and then `ser_clk_o` is high for DIV cycles with `ser_data_o` unchanged. `ser_strobe_o` stays low during shifting, and `ser_clk_o` is high only while `busy_o` is high.
- R7: After the 18th clock pulse, `ser_strobe_o` is high for exactly DIV cycles with `ser_clk_o` low. On the next cycle `done_o` is high for one cycle and `busy_o` is low. From the cycle after `start_i` is sampled to `done_o`, the transfer takes 37·DIV cycles.
- R8: When `mute_i` is 1, the block uses 68 dB whatever the value of `vol_i`, and reports level 0.
- R9: `level_o` equals (v·68/255)·255/68 in integer arithmetic, latched at the start of the transfer.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. The word and level in flight do not change, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| vol_i | input | 8 | Linear volume request, 0..255 |
| mute_i | input | 1 | Force maximum attenuation |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of transfer |
| level_o | output | 8 | Quantised volume actually applied |
| ser_data_o | output | 1 | Serial data line |
| ser_clk_o | output | 1 | Serial clock line |
| ser_strobe_o | output | 1 | Latch strobe line |

## Verification
The assertions check the following on every cycle: the serial clock rises only with data held steady and only while busy, the strobe and the clock are never high together, done lasts a single cycle, and a start during a transfer leaves the held word unchanged. They also check the word's field structure and the attenuation range whenever a start is presented. Only the bench's scenarios can show that the attenuation for each volume lands on the right segment and step. The same holds for the exact order and count of bits on the wire, the reported quantised level, the per-phase durations and the overall latency. To cover these, the bench rebuilds the word from the clock edges and compares it with values worked out by hand for each segment boundary.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int WORD_BITS  = 18;
    localparam int TENS_LSB   = 0;
    localparam int TENS_N     = 7;
    localparam int STEP_LSB   = 7;
    localparam int STEP_N     = 5;
    localparam int GAP_BIT    = 12;
    localparam int LEFT_BIT   = 13;
    localparam int RIGHT_BIT  = 14;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_LOW   = 2'd1,
        SH_HIGH  = 2'd2,
        SH_LATCH = 2'd3
    } shift_state_e;

endpackage

// File: rtl/atten_curve.sv
module atten_curve #(
    parameter int VOL_W   = 8,
    parameter int VOL_MAX = 255,
    parameter int ATT_MAX = 68,
    parameter int ATT_W   = 7
) (
    input  logic [VOL_W-1:0] vol_i,
    input  logic             mute_i,
    output logic [ATT_W-1:0] att_o,
    output logic [VOL_W-1:0] level_o
);

    localparam int unsigned KNEE_LO   = VOL_MAX / 3;
    localparam int unsigned KNEE_HI   = 2 * VOL_MAX / 3;
    localparam int unsigned SLOPE_LO  = 144;
    localparam int unsigned SLOPE_MID = 42;
    localparam int unsigned SLOPE_HI  = 18;
    localparam int unsigned OFS_MID   = 34;
    localparam int unsigned OFS_HI    = 18;
    localparam int unsigned AMAX      = ATT_MAX;
    localparam int unsigned VMAX      = VOL_MAX;

    int unsigned v_d;
    int unsigned att_d;
    int unsigned steps_d;
    int unsigned lvl_d;

    always_comb begin
        v_d = 32'(vol_i);
        if (mute_i || v_d == 0) begin
            att_d = AMAX;
        end else if (v_d <= KNEE_LO) begin
            att_d = AMAX - (SLOPE_LO * v_d) / VMAX;
        end else if (v_d <= KNEE_HI) begin
            att_d = OFS_MID - (SLOPE_MID * v_d) / VMAX;
        end else begin
            att_d = OFS_HI - (SLOPE_HI * v_d) / VMAX;
        end
        steps_d = mute_i ? 0 : (v_d * AMAX) / VMAX;
        lvl_d   = (steps_d * VMAX) / AMAX;
    end

    assign att_o   = ATT_W'(att_d);
    assign level_o = VOL_W'(lvl_d);

endmodule

// File: rtl/atten_word_pack.sv
module atten_word_pack
    import atten_pkg::*;
#(
    parameter int ATT_W = 7
) (
    input  logic [ATT_W-1:0]     att_i,
    output logic [WORD_BITS-1:0] word_o
);

    logic [ATT_W-1:0] tens_d;
    logic [ATT_W-1:0] units_d;
    logic [ATT_W-1:0] step_d;

    always_comb begin
        tens_d  = att_i / ATT_W'(10);
        units_d = att_i - tens_d * ATT_W'(10);
        step_d  = units_d >> 1;
        word_o  = '0;
        for (int k = 0; k < TENS_N; k++) begin
            word_o[TENS_LSB + k] = (tens_d == ATT_W'(k));
        end
        for (int k = 0; k < STEP_N; k++) begin
            word_o[STEP_LSB + k] = (step_d == ATT_W'(k));
        end
        word_o[GAP_BIT]   = 1'b0;
        word_o[LEFT_BIT]  = 1'b1;
        word_o[RIGHT_BIT] = 1'b1;
    end

endmodule

// File: rtl/atten_shifter.sv
module atten_shifter
    import atten_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int LVL_W  = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              ser_strobe_o
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

    typedef struct packed {
        shift_state_e      state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        logic [LVL_W-1:0]  level;
        logic              data;
        logic              sclk;
        logic              stb;
        logic              done;
    } shift_regs_t;

    shift_regs_t r_q;
    shift_regs_t r_d;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        idx_next = r_q.idx + IDX_W'(1);
        case (r_q.state)
            SH_IDLE: begin
                if (start_i) begin
                    r_d.state = SH_LOW;
                    r_d.word  = word_i;
                    r_d.level = level_i;
                    r_d.idx   = '0;
                    r_d.cnt   = '0;
                    r_d.data  = word_i[0];
                    r_d.sclk  = 1'b0;
                end
            end
            SH_LOW: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.cnt   = '0;
                    r_d.state = SH_HIGH;
                    r_d.sclk  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            SH_HIGH: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b0;
                    if (r_q.idx == IDX_LAST) begin
                        r_d.state = SH_LATCH;
                        r_d.stb   = 1'b1;
                        r_d.data  = 1'b0;
                    end else begin
                        r_d.state = SH_LOW;
                        r_d.idx   = idx_next;
                        r_d.data  = r_q.word[idx_next];
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            SH_LATCH: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.cnt   = '0;
                    r_d.stb   = 1'b0;
                    r_d.state = SH_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d.state = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.state != SH_IDLE);
    assign done_o       = r_q.done;
    assign level_o      = r_q.level;
    assign ser_data_o   = r_q.data;
    assign ser_clk_o    = r_q.sclk;
    assign ser_strobe_o = r_q.stb;

    AST_CLK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o |-> busy_o); // R6
    AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> $stable(ser_data_o)); // R6
    AST_STROBE_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ser_strobe_o |-> !ser_clk_o); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(r_q.word) && $stable(level_o))); // R10

endmodule

// File: rtl/atten_link_top.sv
module atten_link_top
    import atten_pkg::*;
#(
    parameter int VOL_W   = 8,
    parameter int VOL_MAX = 255,
    parameter int ATT_MAX = 68,
    parameter int DIV     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VOL_W-1:0] vol_i,
    input  logic             mute_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [VOL_W-1:0] level_o,
    output logic             ser_data_o,
    output logic             ser_clk_o,
    output logic             ser_strobe_o
);

    localparam int ATT_W = $clog2(ATT_MAX + 1);

    logic [ATT_W-1:0]     att_w;
    logic [VOL_W-1:0]     lvl_w;
    logic [WORD_BITS-1:0] word_w;

    atten_curve #(
        .VOL_W  (VOL_W),
        .VOL_MAX(VOL_MAX),
        .ATT_MAX(ATT_MAX),
        .ATT_W  (ATT_W)
    ) u_curve (
        .vol_i  (vol_i),
        .mute_i (mute_i),
        .att_o  (att_w),
        .level_o(lvl_w)
    );

    atten_word_pack #(
        .ATT_W(ATT_W)
    ) u_pack (
        .att_i (att_w),
        .word_o(word_w)
    );

    atten_shifter #(
        .WORD_W(WORD_BITS),
        .LVL_W (VOL_W),
        .DIV   (DIV)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .word_i      (word_w),
        .level_i     (lvl_w),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .level_o     (level_o),
        .ser_data_o  (ser_data_o),
        .ser_clk_o   (ser_clk_o),
        .ser_strobe_o(ser_strobe_o)
    );

    AST_ATT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (att_w <= ATT_W'(ATT_MAX))); // R2
    AST_TENS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ($countones(word_w[TENS_LSB +: TENS_N]) == 1)); // R3
    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ($countones(word_w[STEP_LSB +: STEP_N]) == 1)); // R4
    AST_CHAN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (word_w[LEFT_BIT] && word_w[RIGHT_BIT] && !word_w[GAP_BIT]
                     && word_w[WORD_BITS-1:RIGHT_BIT+1] == '0)); // R5
    AST_MUTE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mute_i) |-> (att_w == ATT_W'(ATT_MAX) && lvl_w == '0)); // R8

endmodule

// File: tb/atten_link_top_bench.sv
module atten_link_top_bench;

    localparam int DIV = 3;
    localparam int NV  = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] vol_i = '0;
    logic       mute_i = 1'b0;
    logic       busy_o, done_o, ser_data_o, ser_clk_o, ser_strobe_o;
    logic [7:0] level_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // {vol, mute, expected word, expected level}
    localparam logic [34:0] VEC [NV] = '{
        {8'd0,   1'b0, 18'h06840, 8'd0},
        {8'd1,   1'b0, 18'h06840, 8'd0},
        {8'd2,   1'b0, 18'h06440, 8'd0},
        {8'd30,  1'b0, 18'h06120, 8'd30},
        {8'd50,  1'b0, 18'h06090, 8'd48},
        {8'd85,  1'b0, 18'h06084, 8'd82},
        {8'd86,  1'b0, 18'h06084, 8'd82},
        {8'd100, 1'b0, 18'h06802, 8'd97},
        {8'd170, 1'b0, 18'h06401, 8'd168},
        {8'd171, 1'b0, 18'h06401, 8'd168},
        {8'd200, 1'b0, 18'h06201, 8'd198},
        {8'd255, 1'b0, 18'h06081, 8'd255},
        {8'd255, 1'b1, 18'h06840, 8'd0}
    };

    atten_link_top #(.DIV(DIV)) u_atten_link_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vol_i(vol_i),
        .mute_i(mute_i), .busy_o(busy_o), .done_o(done_o), .level_o(level_o),
        .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o),
        .ser_strobe_o(ser_strobe_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Launches one transfer and rebuilds the word from the serial lines.
    task automatic xfer(input logic [7:0] v, input logic m, input bit poke_busy,
                        output logic [17:0] word, output int lat, output bit timing_ok,
                        output int nbits);
        bit prev_clk = 0;
        int hi_run = 0, stb_run = 0, stb_pulses = 0, n = 0;
        timing_ok = 1;
        nbits = 0;
        word = '0;
        @(negedge clk);
        vol_i = v; mute_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && n < 2000) begin
            n++;
            if (poke_busy && n == 10) begin
                start_i = 1'b1; vol_i = ~v; mute_i = ~m;
            end
            if (poke_busy && n == 11) start_i = 1'b0;
            if (ser_clk_o && !prev_clk) begin
                if (nbits < 18) word[nbits] = ser_data_o;
                nbits++;
            end
            if (ser_clk_o) hi_run++;
            else if (prev_clk) begin
                if (hi_run != DIV) timing_ok = 0;
                hi_run = 0;
            end
            if (ser_strobe_o) begin
                if (nbits != 18 || ser_clk_o) timing_ok = 0;
                stb_run++;
            end else if (stb_run != 0) begin
                if (stb_run != DIV) timing_ok = 0;
                stb_pulses++;
                stb_run = 0;
            end
            if (!busy_o) timing_ok = 0;
            prev_clk = ser_clk_o;
            @(negedge clk);
        end
        if (stb_run != 0) begin
            if (stb_run != DIV) timing_ok = 0;
            stb_pulses++;
        end
        if (stb_pulses != 1 || busy_o) timing_ok = 0;
        lat = n + 1;
    endtask

    initial begin
        logic [17:0] w;
        int lat, nb;
        bit tok;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({ser_data_o, ser_clk_o, ser_strobe_o, busy_o, done_o} == 5'b0 && level_o == 0,
              "R1", {level_o, ser_data_o, ser_clk_o, ser_strobe_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !ser_clk_o && !ser_strobe_o, "R1", busy_o, 0);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][34:27], VEC[i][26], 1'b0, w, lat, tok, nb);
            // R2 R3 R4 R5 R8: rebuilt word matches hand-computed encoding
            check(w == VEC[i][25:8], (VEC[i][26] ? "R8" : "R2/R3/R4/R5 word"), int'(w), int'(VEC[i][25:8]));
            // R9 R8 reported level
            check(level_o == VEC[i][7:0], "R9 level", level_o, VEC[i][7:0]);
            // R6 R7 bit count, phase widths, strobe, latency
            check(tok && nb == 18, "R6 timing", nb, 18);
            check(lat == 37 * DIV + 1, "R7 latency", lat, 37 * DIV + 1);
            check(done_o && !busy_o, "R7 done", done_o, 1);
            @(negedge clk);
            check(!done_o, "R7 done single", done_o, 0);
        end

        // R10: start during busy is ignored
        xfer(8'd255, 1'b0, 1'b1, w, lat, tok, nb);
        check(w == 18'h06081, "R10 word", int'(w), 'h6081);
        check(level_o == 8'd255, "R10 level", level_o, 255);
        check(tok && lat == 37 * DIV + 1, "R10 timing", lat, 37 * DIV + 1);
        repeat (5) begin
            @(negedge clk);
            check(!busy_o && !ser_clk_o, "R10 no second transfer", busy_o, 0);
        end

        // R8: mute with mid volume, then R4 odd step again with no mute
        xfer(8'd100, 1'b1, 1'b0, w, lat, tok, nb);
        check(w == 18'h06840 && level_o == 0, "R8 mute mid", int'(w), 'h6840);
        xfer(8'd2, 1'b0, 1'b0, w, lat, tok, nb);
        check(w == 18'h06440, "R4 odd step", int'(w), 'h6440);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule